// File: doc/BRIEF.md
# Integer Condition-Flag Generator

This unit takes two integer operands, an operation code and a size code, and produces the arithmetic result together with five condition flags: extend (X), negative (N), zero (Z), overflow (V) and carry/borrow (C). It handles four operations: plain add, plain subtract, add-with-extend and subtract-with-extend. The flags come straight from the operands in the cycle the operation is presented. When a valid strobe is high, the result and the new flags are captured in output registers.

The caller supplies the current flag register on `flags_i` and feeds `flags_o` back into it. The extend operations take the old X bit as a carry or borrow input. They can clear Z but never set it. Because of this, a chain of long operations over a multi-word number leaves Z set only when every word of the result was zero.

Plain add and subtract work on a byte, word or long slice of the operands. The extend operations always work on the full long width.

Top module: `ccflag_unit`

## Requirements
- R1: While reset is asserted, and after it is released, `result_o` and `flags_o` read zero until the first valid operation.
- R2: The outputs change only on a rising clock edge with `valid_i` high. With `valid_i` low they hold their value whatever the other inputs do.
- R3: Op code 0 (add) gives a+b at the selected width. C is the carry out of that width, and X takes the same value as C.
- R4: Op code 1 (subtract) gives a−b at the selected width. C is set when a is unsigned-less-than b at that width, and X takes the same value as C.
- R5: V for add and add-with-extend is the top bit of (res^a)&(res^b). V for subtract and subtract-with-extend is the top bit of (a^b)&(a^res). The top bit is taken at the operating width.
- R6: N is the sign bit of the result at the operating width. For the plain ops, Z is set exactly when the result at that width is zero.
- R7: Size code 0 selects 8 bits, 1 selects 16 bits and 2 selects 32 bits. The reserved code 3 acts as 32 bits. Operand bits above the selected width are ignored, and the result is zero-extended to 32 bits.
- R8: Op code 2 (add-with-extend) gives a+b+X. C and X are set when res≤b if the old X was 1, or when res<b if the old X was 0.
- R9: Op code 3 (subtract-with-extend) gives a−b−X. C and X are set when a≤b if the old X was 1, or when a<b if the old X was 0.
- R10: For the extend ops, the new Z is the zero test of the result ANDed with the old Z. A nonzero result clears Z, and a zero result leaves Z as it was.
- R11: The extend ops always work at 32 bits, whatever size code is given.
- R12: The flag bits are packed {X,N,Z,V,C} in bits 4 down to 0. The plain ops ignore `flags_i` entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Capture strobe for the result and flags |
| op_i | input | 2 | 0 add, 1 subtract, 2 add-with-extend, 3 subtract-with-extend |
| size_i | input | 2 | 0 byte, 1 word, 2 long, 3 treated as long |
| a_i | input | DATA_W | First operand (minuend for subtraction) |
| b_i | input | DATA_W | Second operand (subtrahend for subtraction) |
| flags_i | input | 5 | Current flag register {X,N,Z,V,C} |
| result_o | output | DATA_W | Registered result, zero-extended |
| flags_o | output | 5 | Registered new flags {X,N,Z,V,C} |

## Verification
The bench builds the unit only with the default DATA_W of 32. This gives byte, word and long slices of 8, 16 and 32 bits. At these widths, hand-computed vectors can reach every carry, borrow, signed overflow and zero boundary. The vectors include the following cases:
- Extend operations at both values of the old X and the old Z, including equal operands, where the ≤ and < rules part ways.
- Narrow operations whose upper operand bits are nonzero.
- Extend operations given a narrow size code.

// File: rtl/ccflag_pkg.sv
package ccflag_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_ADDX = 2'd2,
        OP_SUBX = 2'd3
    } ccf_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } ccf_size_e;

    // Flag register layout, bit 4 down to bit 0 (R12)
    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccf_flags_t;

    localparam int NUM_SIZES = 3;

endpackage

// File: rtl/ccflag_arith.sv
module ccflag_arith #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         cin_i,
    output logic [W-1:0] res_o,
    output logic         carry_o,
    output logic         ovf_o,
    output logic         neg_o,
    output logic         zero_o
);

    logic [W:0] wide;

    always_comb begin
        // One extra bit holds the carry out (add) or the borrow out (subtract)
        if (sub_i) begin
            wide = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
        end else begin
            wide = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
        end
        res_o   = wide[W-1:0];
        carry_o = wide[W];
        if (sub_i) begin
            ovf_o = (a_i[W-1] ^ b_i[W-1]) & (a_i[W-1] ^ res_o[W-1]);
        end else begin
            ovf_o = (res_o[W-1] ^ a_i[W-1]) & (res_o[W-1] ^ b_i[W-1]);
        end
        neg_o  = res_o[W-1];
        zero_o = (res_o == '0);
    end

endmodule

// File: rtl/ccflag_merge.sv
module ccflag_merge
    import ccflag_pkg::*;
(
    input  logic       carry_i,
    input  logic       ovf_i,
    input  logic       neg_i,
    input  logic       zero_i,
    input  logic       extend_i,
    input  logic       prev_z_i,
    output ccf_flags_t flags_o
);

    always_comb begin
        flags_o.c = carry_i;
        flags_o.x = carry_i;
        flags_o.v = ovf_i;
        flags_o.n = neg_i;
        // Extend ops may only clear Z (R10)
        flags_o.z = extend_i ? (zero_i & prev_z_i) : zero_i;
    end

endmodule

// File: rtl/ccflag_unit.sv
module ccflag_unit
    import ccflag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [1:0]        op_i,
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [4:0]        flags_i,
    output logic [DATA_W-1:0] result_o,
    output logic [4:0]        flags_o
);

    localparam int SEL_W = $clog2(NUM_SIZES);

    typedef struct packed {
        logic [DATA_W-1:0] result;
        ccf_flags_t        flags;
    } state_t;

    state_t st_d, st_q;

    ccf_op_e    op;
    ccf_flags_t prev;
    logic       is_sub, is_ext;
    logic [SEL_W-1:0] sel;

    logic [DATA_W-1:0]    res_w   [NUM_SIZES];
    logic [NUM_SIZES-1:0] carry_w, ovf_w, neg_w, zero_w;

    assign op     = ccf_op_e'(op_i);
    assign prev   = ccf_flags_t'(flags_i);
    assign is_sub = (op == OP_SUB) || (op == OP_SUBX);
    assign is_ext = (op == OP_ADDX) || (op == OP_SUBX);

    // One arithmetic slice per operand width: DATA_W/4, DATA_W/2, DATA_W
    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_width
        localparam int KW = DATA_W >> (NUM_SIZES - 1 - k);
        logic [KW-1:0] slice_res;

        ccflag_arith #(.W(KW)) u_arith (
            .a_i     (a_i[KW-1:0]),
            .b_i     (b_i[KW-1:0]),
            .sub_i   (is_sub),
            .cin_i   (is_ext & prev.x),
            .res_o   (slice_res),
            .carry_o (carry_w[k]),
            .ovf_o   (ovf_w[k]),
            .neg_o   (neg_w[k]),
            .zero_o  (zero_w[k])
        );

        assign res_w[k] = DATA_W'(slice_res);
    end

    always_comb begin
        // Extend ops and the reserved code run at full width (R7, R11)
        if (is_ext || ccf_size_e'(size_i) == SZ_RSVD) begin
            sel = SEL_W'(SZ_LONG);
        end else begin
            sel = SEL_W'(size_i);
        end
    end

    ccf_flags_t new_flags;

    ccflag_merge u_merge (
        .carry_i  (carry_w[sel]),
        .ovf_i    (ovf_w[sel]),
        .neg_i    (neg_w[sel]),
        .zero_i   (zero_w[sel]),
        .extend_i (is_ext),
        .prev_z_i (prev.z),
        .flags_o  (new_flags)
    );

    always_comb begin
        st_d = st_q;
        if (valid_i) begin
            st_d.result = res_w[sel];
            st_d.flags  = new_flags;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.result;
    assign flags_o  = st_q.flags;

endmodule

// File: rtl/ccflag_unit_chk.sv
module ccflag_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic [1:0]        op_i,
    input logic [1:0]        size_i,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic [4:0]        flags_i,
    input logic [DATA_W-1:0] result_o,
    input logic [4:0]        flags_o
);

    localparam int BYTE_W = DATA_W / 4;

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(result_o) && $stable(flags_o)));

    assert_x_follows_c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (flags_o[4] == flags_o[0]));

    assert_byte_zero_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !op_i[1] && size_i == 2'd0) |=> (result_o[DATA_W-1:BYTE_W] == '0));

    assert_ext_never_sets_z_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i[1] && !flags_i[2]) |=> !flags_o[2]);

    assert_ext_nonzero_clears_z_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i[1]) |=> (result_o == '0 || !flags_o[2]));

    assert_ext_long_sign_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i[1]) |=> (flags_o[3] == result_o[DATA_W-1]));

endmodule

bind ccflag_unit ccflag_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/ccflag_unit_bench.sv
module ccflag_unit_bench;

    localparam int DW = 32;
    localparam int NV = 17;

    typedef struct packed {
        logic [1:0]    op;
        logic [1:0]    sz;
        logic [4:0]    fin;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [DW-1:0] er;
        logic [4:0]    ef;
        logic [7:0]    req;
    } vec_t;

    // flags {X,N,Z,V,C}
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd2, 5'b00000, 32'h1, 32'h2, 32'h3, 5'b00000, 8'd3},                          // R3
        '{2'd0, 2'd2, 5'b00000, 32'hFFFFFFFF, 32'h1, 32'h0, 5'b10101, 8'd6},                    // R6 R3
        '{2'd0, 2'd2, 5'b00000, 32'h7FFFFFFF, 32'h1, 32'h80000000, 5'b01010, 8'd5},             // R5
        '{2'd1, 2'd2, 5'b00000, 32'h5, 32'h7, 32'hFFFFFFFE, 5'b11001, 8'd4},                    // R4
        '{2'd1, 2'd2, 5'b00000, 32'h80000000, 32'h1, 32'h7FFFFFFF, 5'b00010, 8'd5},             // R5
        '{2'd1, 2'd0, 5'b00000, 32'h12345610, 32'hABCDEF20, 32'h000000F0, 5'b11001, 8'd7},      // R7
        '{2'd0, 2'd1, 5'b00000, 32'h00018000, 32'hFFFF8000, 32'h0, 5'b10111, 8'd7},             // R7 R5
        '{2'd0, 2'd3, 5'b00000, 32'h1, 32'h1, 32'h2, 5'b00000, 8'd7},                           // R7 reserved
        '{2'd2, 2'd2, 5'b10100, 32'h1, 32'h1, 32'h3, 5'b00000, 8'd8},                           // R8
        '{2'd2, 2'd2, 5'b10100, 32'hFFFFFFFF, 32'h0, 32'h0, 5'b10101, 8'd10},                   // R10 R8
        '{2'd2, 2'd2, 5'b10000, 32'hFFFFFFFF, 32'h0, 32'h0, 5'b10001, 8'd10},                   // R10
        '{2'd3, 2'd2, 5'b10100, 32'h5, 32'h5, 32'hFFFFFFFF, 5'b11001, 8'd9},                    // R9
        '{2'd3, 2'd2, 5'b00100, 32'h5, 32'h5, 32'h0, 5'b00100, 8'd9},                           // R9 R10
        '{2'd3, 2'd0, 5'b10100, 32'h100, 32'h0, 32'hFF, 5'b00000, 8'd11},                       // R11
        '{2'd0, 2'd2, 5'b11111, 32'h2, 32'h3, 32'h5, 5'b00000, 8'd12},                          // R12
        '{2'd1, 2'd1, 5'b00000, 32'h00008000, 32'h00000001, 32'h00007FFF, 5'b00010, 8'd5},      // R5 R7
        '{2'd2, 2'd0, 5'b00100, 32'h80000000, 32'h80000000, 32'h0, 5'b10111, 8'd11}             // R11
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid_i = 1'b0;
    logic [1:0]    op_i = '0;
    logic [1:0]    size_i = '0;
    logic [DW-1:0] a_i = '0;
    logic [DW-1:0] b_i = '0;
    logic [4:0]    flags_i = '0;
    logic [DW-1:0] result_o;
    logic [4:0]    flags_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ccflag_unit #(.DATA_W(DW)) u_ccflag_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (valid_i),
        .op_i     (op_i),
        .size_i   (size_i),
        .a_i      (a_i),
        .b_i      (b_i),
        .flags_i  (flags_i),
        .result_o (result_o),
        .flags_o  (flags_o)
    );

    task automatic check(input string req, input logic [DW-1:0] er, input logic [4:0] ef);
        tests++;
        if (result_o !== er || flags_o !== ef) begin
            fails++;
            $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
                     req, result_o, flags_o, er, ef);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] op, input logic [1:0] sz,
                         input logic [4:0] fin, input logic [DW-1:0] a, input logic [DW-1:0] b);
        @(negedge clk);
        valid_i = v; op_i = op; size_i = sz; flags_i = fin; a_i = a; b_i = b;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 during reset", '0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", '0, '0);

        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VECS[i].op, VECS[i].sz, VECS[i].fin, VECS[i].a, VECS[i].b);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].er, VECS[i].ef);
        end

        // R2: hold with valid low while inputs change
        drive(1'b1, 2'd1, 2'd2, 5'b00000, 32'h5, 32'h7);
        drive(1'b0, 2'd0, 2'd2, 5'b00000, 32'h1, 32'h1);
        check("R2 hold", 32'hFFFFFFFE, 5'b11001);
        drive(1'b0, 2'd3, 2'd0, 5'b11111, 32'h0, 32'h9);
        check("R2 hold again", 32'hFFFFFFFE, 5'b11001);

        // R10: two-word chain, low word zero then high word zero keeps Z
        drive(1'b1, 2'd1, 2'd2, 5'b00000, 32'h0, 32'h0);
        check("R4 low word", 32'h0, 5'b00100);
        drive(1'b1, 2'd3, 2'd2, flags_o, 32'h0, 32'h0);
        check("R10 chain zero", 32'h0, 5'b00100);

        // R1: reset mid-stream clears registered state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset", '0, '0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: expected completion, got timeout");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule